// File: doc/BRIEF.md
# Two-wire serial EEPROM target controller

This block is the bus-facing side of a two-wire serial EEPROM. It runs on a system clock much faster than SCL and takes SCL and SDA as already synchronised inputs. From the samples it finds SCL edges and the start and stop conditions. It answers on the bus only through an open-drain pull-down enable for SDA. A transaction begins with a select byte that carries a fixed device code, three chip-select bits and a direction bit. Write transactions then carry a word address and data bytes. Read transactions return bytes from an internal address counter for as long as the host keeps acknowledging them.

The array itself sits outside the block, behind a synchronous read port of 2**ADDR_W bytes. A read data byte is returned one clock after its request. Writes go to a separate write engine. Each accepted data byte is offered as an address and data pulse. A stop condition then asks the engine to commit the bytes it has collected, and a repeated start asks it to discard them. While the engine reports that it is busy, the block refuses its own select byte, so the host can poll until the commit has finished.

Top module: `twi_eeprom_target`

## Requirements
- R1: Bus activity before the first start condition is ignored, and a select byte clocked in without a start receives no ACK. A start condition (SDA falling while SCL is high) is recognised in any state, even in the middle of a byte, and restarts select-byte reception. After reset, sda_oe_o, mem_rd_o and all write-engine pulses are 0.
- R2: A stop condition (SDA rising while SCL is high) ends the command. If data bytes were accepted since the last start, wr_commit_o pulses for one cycle.
- R3: The select byte is taken MSB first: bits 7..4 must be 1010, bits 3..1 must equal chip_sel_i, and bit 0 is the direction (0 write, 1 read). Any other byte gets no ACK, and the bus is then ignored until the next start, so later bytes get no ACK either.
- R4: After a matching select byte, and after every word-address and data byte in a write transaction, SDA is pulled low for the ninth clock. The pull-down is applied only after SCL has fallen.
- R5: The first data byte of a write goes to the word address. Each following byte goes to the next address within the same page of 2**PAGE_BITS bytes, wrapping from the end of the page back to its start. Each byte is presented as a wr_byte_o pulse with wr_addr_o and wr_data_o.
- R6: Read bytes are sent MSB first. SDA changes only after SCL falls and stays stable while SCL is high. Data comes from the memory port, with mem_rdata_i valid one clock after mem_rd_o.
- R7: In a read, a low host ACK after the eighth bit makes the block send the byte at the next address. A high ACK makes the block release SDA and ignore the bus until the next start or stop.
- R8: A current-address read (a read select with no preceding word address) returns the byte at last address + 1 after a read, and the byte at the last written address after a write.
- R9: A random read (a write select, then a word address, then a repeated start and a read select) returns the byte at that word address. Sequential reading continues from there.
- R10: During sequential reads the address counter wraps from 2**ADDR_W-1 to 0.
- R11: While wr_busy_i is high, neither a read nor a write select byte receives an ACK.
- R12: A repeated start after accepted data bytes pulses wr_abort_o and does not pulse wr_commit_o, so the array keeps its old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversampling SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| chip_sel_i | input | 3 | Chip-select strap compared with select bits 3..1 |
| sda_oe_o | output | 1 | SDA pull-down enable (1 drives SDA low) |
| mem_rd_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one clock after mem_rd_o |
| wr_byte_o | output | 1 | Write-engine byte pulse |
| wr_addr_o | output | ADDR_W | Address of the offered byte |
| wr_data_o | output | 8 | Offered byte |
| wr_commit_o | output | 1 | Commit pulse on stop |
| wr_abort_o | output | 1 | Discard pulse on repeated start |
| wr_busy_i | input | 1 | Write engine busy; select bytes are refused |

## Verification
On every cycle the assertions check that the pull-down is only ever switched on while SCL is low and that memory fetches happen only in the SCL low phase. They also check that a busy write engine never gets its select byte acknowledged, and that a commit leaves the controller idle. Inside the address counter they check that page stepping keeps the page bits and that sequential stepping adds one with wrap. The bench scenarios are the only place where results tied to specific addresses can be shown. These include the n versus n+1 rule for current reads, page wrap of written data, the select-byte sweep, the effect of a NACK on the rest of the read, and the fact that an aborted write leaves the array unchanged.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WADDR,
    ST_WDATA,
    ST_RD
  } twi_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_BITS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              page_inc_i,
  input  logic              seq_inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] page_next_o
);
  localparam int unsigned HI_W = ADDR_W - PAGE_BITS;

  logic [PAGE_BITS-1:0] low_next;

  assign low_next    = addr_o[PAGE_BITS-1:0] + 1'b1;
  assign page_next_o = {addr_o[ADDR_W-1:PAGE_BITS], low_next};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_o <= '0;
    else if (load_i)     addr_o <= load_val_i;
    else if (page_inc_i) addr_o <= page_next_o;
    else if (seq_inc_i)  addr_o <= addr_o + 1'b1;
  end

  // page stepping keeps the page number
  assert_page_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_inc_i && !load_i) |=> (addr_o[ADDR_W-1:PAGE_BITS] == $past(addr_o[ADDR_W-1:PAGE_BITS])));

  // sequential stepping adds one with wrap at the top
  assert_seq_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_inc_i && !load_i && !page_inc_i) |=> (addr_o == $past(addr_o) + 1'b1));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = page_next_o[ADDR_W-1:PAGE_BITS];
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_BITS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  output logic              sda_oe_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              wr_byte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              wr_abort_o,
  input  logic              wr_busy_i
);
  localparam logic [3:0] LAST_SLOT = 4'd8;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  twi_state_e state_q, after_q;
  logic [3:0] cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic first_q, pend_q, load_q;
  logic [ADDR_W-1:0] cur_addr, page_next;
  logic ctr_load, ctr_page, ctr_seq, sel_ok, slot_fall;

  twi_bus_events u_ev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  assign slot_fall = scl_fall && (cnt_q == LAST_SLOT);
  assign ctr_load  = slot_fall && (state_q == ST_WADDR);
  assign ctr_page  = slot_fall && (state_q == ST_WDATA) && !first_q;
  assign ctr_seq   = scl_rise && (cnt_q == 4'd7) && (state_q == ST_RD);
  assign sel_ok    = (rx_q[7:4] == DEV_CODE) && (rx_q[3:1] == chip_sel_i) && !wr_busy_i;

  twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ctr_load),
    .load_val_i  (rx_q[ADDR_W-1:0]),
    .page_inc_i  (ctr_page),
    .seq_inc_i   (ctr_seq),
    .addr_o      (cur_addr),
    .page_next_o (page_next)
  );

  assign mem_addr_o = cur_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      after_q     <= ST_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '1;
      first_q     <= 1'b0;
      pend_q      <= 1'b0;
      load_q      <= 1'b0;
      sda_oe_o    <= 1'b0;
      mem_rd_o    <= 1'b0;
      wr_byte_o   <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
      wr_abort_o  <= 1'b0;
    end else begin
      mem_rd_o    <= 1'b0;
      wr_byte_o   <= 1'b0;
      wr_commit_o <= 1'b0;
      wr_abort_o  <= 1'b0;
      load_q      <= mem_rd_o;
      if (load_q) tx_q <= mem_rdata_i;

      if (start_ev) begin
        state_q    <= ST_SEL;
        cnt_q      <= '0;
        sda_oe_o   <= 1'b0;
        wr_abort_o <= pend_q;
        pend_q     <= 1'b0;
      end else if (stop_ev) begin
        state_q     <= ST_IDLE;
        sda_oe_o    <= 1'b0;
        wr_commit_o <= pend_q;
        pend_q      <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt_q != LAST_SLOT) begin
            rx_q  <= {rx_q[6:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else begin
            cnt_q <= '0;
            if (state_q == ST_RD) begin
              if (sda_i) state_q <= ST_IDLE;   // host NACK
            end else begin
              state_q <= after_q;
            end
          end
        end else if (scl_fall) begin
          if (state_q == ST_RD) begin
            if (cnt_q != LAST_SLOT) begin
              sda_oe_o <= ~tx_q[7];
              tx_q     <= {tx_q[6:0], 1'b1};
            end else begin
              sda_oe_o <= 1'b0;                // host ACK slot, prefetch
              mem_rd_o <= 1'b1;
            end
          end else if (cnt_q == LAST_SLOT) begin
            case (state_q)
              ST_SEL: begin
                if (sel_ok) begin
                  sda_oe_o <= 1'b1;
                  if (rx_q[0]) begin
                    after_q  <= ST_RD;
                    mem_rd_o <= 1'b1;
                  end else begin
                    after_q <= ST_WADDR;
                  end
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_WADDR: begin
                sda_oe_o <= 1'b1;
                first_q  <= 1'b1;
                after_q  <= ST_WDATA;
              end
              ST_WDATA: begin
                sda_oe_o  <= 1'b1;
                first_q   <= 1'b0;
                wr_byte_o <= 1'b1;
                wr_addr_o <= first_q ? cur_addr : page_next;
                wr_data_o <= rx_q;
                pend_q    <= 1'b1;
                after_q   <= ST_WDATA;
              end
              default: sda_oe_o <= 1'b0;
            endcase
          end else if (cnt_q == 4'd0) begin
            sda_oe_o <= 1'b0;
          end
        end
      end
    end
  end

  assert_ack_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  assert_fetch_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !scl_i);

  assert_busy_no_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL && wr_busy_i) |=> !$rose(sda_oe_o));

  assert_commit_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> (state_q == ST_IDLE && !sda_oe_o));
endmodule

// File: tb/twi_eeprom_target_test.sv
`timescale 1ns/1ps
module twi_eeprom_target_test;
  localparam logic [7:0] SEL_W = 8'hAA;  // 1010 101 0
  localparam logic [7:0] SEL_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1, busy = 1'b0;
  logic sda_oe, mem_rd, wr_byte, wr_commit, wr_abort;
  logic [7:0] mem_addr, wr_addr, wr_data, rdata;
  wire sda_bus = msda & ~sda_oe;

  int n_cmp = 0, n_bad = 0, commits = 0, aborts = 0, pn = 0;
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  logic [7:0] pa [16];
  logic [7:0] pd [16];
  logic [7:0] wbuf [8];
  logic [7:0] exp_ptr;
  logic done = 1'b0;

  always #10 clk = ~clk;

  twi_eeprom_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .chip_sel_i(3'b101), .sda_oe_o(sda_oe), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_rdata_i(rdata), .wr_byte_o(wr_byte),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit),
    .wr_abort_o(wr_abort), .wr_busy_i(busy)
  );

  // memory and write-engine model
  always @(posedge clk) begin
    if (mem_rd) rdata <= mem[mem_addr];
    if (wr_byte && pn < 16) begin pa[pn] <= wr_addr; pd[pn] <= wr_data; pn <= pn + 1; end
    if (wr_commit) begin
      for (int k = 0; k < 16; k++) if (k < pn) mem[pa[k]] <= pd[k];
      pn <= 0; commits <= commits + 1;
    end
    if (wr_abort) begin pn <= 0; aborts <= aborts + 1; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait; repeat (3) @(negedge clk); endtask

  task automatic wbit(input logic b);
    msda = b; qwait; scl = 1'b1; qwait; qwait; scl = 1'b0; qwait;
  endtask

  task automatic rbit(output logic b);
    logic b2;
    msda = 1'b1; qwait; scl = 1'b1; qwait; b = sda_bus; qwait; b2 = sda_bus;
    scl = 1'b0; qwait;
    if (b !== b2) check("R6 stable while SCL high", b2, b);
  endtask

  task automatic bus_start;
    msda = 1'b1; qwait; scl = 1'b1; qwait; msda = 1'b0; qwait; scl = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    msda = 1'b0; qwait; scl = 1'b1; qwait; msda = 1'b1; qwait;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(ack);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    send(b, a);
    check(tag, a, exp_ack);
  endtask

  task automatic recv(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(b[i]);
    wbit(nack);
  endtask

  task automatic rd_seq(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv(b, k == n - 1);
      check(tag, b, refm[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
    end
    bus_stop;
  endtask

  task automatic wr_txn(input logic [7:0] addr, input int n);
    logic [7:0] a;
    int c0;
    c0 = commits;
    bus_start;
    send_chk(SEL_W, 1'b0, "R4 ack write select");
    send_chk(addr, 1'b0, "R4 ack word address");
    a = addr;
    for (int k = 0; k < n; k++) begin
      send_chk(wbuf[k], 1'b0, "R4 ack data");
      refm[a] = wbuf[k];
      exp_ptr = a;
      a = {a[7:3], a[2:0] + 3'd1};
    end
    bus_stop;
    qwait;
    check("R2 commit on stop", commits, c0 + 1);
  endtask

  task automatic rand_rd(input logic [7:0] addr, input int n, input string tag);
    bus_start;
    send_chk(SEL_W, 1'b0, "R9 dummy write select");
    send_chk(addr, 1'b0, "R9 word address");
    bus_start;
    send_chk(SEL_R, 1'b0, "R9 read select");
    exp_ptr = addr;
    rd_seq(n, tag);
  endtask

  task automatic cur_rd(input int n, input string tag);
    bus_start;
    send_chk(SEL_R, 1'b0, "R8 read select");
    rd_seq(n, tag);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    int c0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37 + 11) & 255);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check("R1 reset sda_oe", sda_oe, 0);
    check("R1 reset mem_rd", mem_rd, 0);
    check("R1 reset wr pulses", {wr_byte, wr_commit, wr_abort}, 0);
    rst_n = 1'b1;
    qwait;

    // R1: select without a start
    send_chk(SEL_W, 1'b1, "R1 no start no ack");
    bus_stop;

    // R3: chip-select sweep, then ignored follow-up byte
    for (int cs = 0; cs < 8; cs++) begin
      bus_start;
      send({4'b1010, 3'(cs), 1'b0}, a);
      check("R3 chip select sweep", a, (cs == 5) ? 1'b0 : 1'b1);
      if (cs != 5) send_chk(8'h00, 1'b1, "R3 ignored until start");
      bus_stop;
    end
    for (int c = 0; c < 16; c++) begin
      bus_start;
      send({4'(c), 3'b101, 1'b0}, a);
      check("R3 device code sweep", a, (c == 10) ? 1'b0 : 1'b1);
      bus_stop;
    end

    // R5 byte write then R9 random read
    wbuf[0] = 8'h5A;
    wr_txn(8'h20, 1);
    rand_rd(8'h20, 1, "R9 random read");

    // R5 page wrap, R8 current read after write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_txn(8'h3E, 4);
    check("R5 wrap target", refm[8'h39], 8'h44);
    cur_rd(1, "R8 current read after write");
    rand_rd(8'h38, 8, "R7 sequential page read");

    // R8 current read after read
    rand_rd(8'h10, 1, "R9 random read");
    cur_rd(2, "R8 current read after read");

    // R10 wrap
    rand_rd(8'hFE, 4, "R10 address wrap");

    // R11 busy
    busy = 1'b1;
    bus_start; send_chk(SEL_W, 1'b1, "R11 busy write select"); bus_stop;
    bus_start; send_chk(SEL_R, 1'b1, "R11 busy read select"); bus_stop;
    busy = 1'b0;
    cur_rd(1, "R11 after busy");

    // R7 NACK releases the bus
    bus_start;
    send_chk(SEL_R, 1'b0, "R7 read select");
    recv(b, 1'b1);
    check("R7 byte before nack", b, refm[exp_ptr]);
    recv(b, 1'b1);
    check("R7 released after nack", b, 8'hFF);
    bus_stop;

    // R12 repeated start aborts write
    c0 = commits;
    bus_start;
    send_chk(SEL_W, 1'b0, "R12 select");
    send_chk(8'h50, 1'b0, "R12 address");
    send_chk(8'hAA, 1'b0, "R12 data");
    bus_start;
    send_chk(SEL_R, 1'b0, "R12 read select");
    recv(b, 1'b1);
    check("R12 old content kept", b, refm[8'h50]);
    bus_stop;
    check("R12 abort pulse", aborts, 1);
    check("R12 no commit", commits, c0);

    // R1 start in the middle of a byte
    bus_start;
    send_chk(SEL_W, 1'b0, "R1 select");
    send_chk(8'h60, 1'b0, "R1 address");
    wbit(1'b0); wbit(1'b1); wbit(1'b0);
    bus_start;
    send_chk(SEL_R, 1'b0, "R1 restart mid byte");
    recv(b, 1'b1);
    check("R1 read after restart", b, refm[8'h60]);
    bus_stop;

    // full-array sweep: page writes then one sequential read
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 8; k++) wbuf[k] = 8'((p * 8 + k) ^ 8'hC3);
      wr_txn(8'(p * 8), 8);
    end
    rand_rd(8'h00, 256, "R7 full array read");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule